// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Return-Address Stacking

This block turns a pending reset request or hardware interrupt into the short multi-cycle entry sequence that a small processor core runs before it fetches the first handler instruction. When global interrupts are enabled and a request is present, the block captures the current program counter and stack pointer, then writes the return address to data memory one byte per cycle. Each byte goes to the address held in the stack pointer, and the stack pointer moves down by one after each byte.

After the last byte, the block drives a single load cycle. In that cycle it presents the handler address, the final stack pointer, a strobe that tells the core to drop its global interrupt enable, and a one-hot clear for the serviced source. Two configuration straps set the number of stacked bytes and the spacing of the vector table. The core holds its fetch stage while `busy` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only on a clock edge where `busy` is low, `gie` is 1, and either `rst_req` is 1 or at least one `irq_pend` bit is 1. In every other case `busy`, `mem_we` and `pc_load` stay 0.
- R2: If `rst_req` and pending sources are present at the same accepting edge, the reset is serviced. It uses vector number 0, and `src_clr` stays all-zero.
- R3: For a hardware interrupt, the lowest-indexed set bit of `irq_pend` is serviced. Its vector number is that bit index plus 1.
- R4: `src_clr` is high for exactly one cycle, the load cycle. In that cycle it has only the serviced source's bit set.
- R5: In the load cycle, `pc_out` equals the vector number times 2 when `cfg_long_vec` is 1, and the vector number times 1 when `cfg_long_vec` is 0.
- R6: The number of stacked bytes follows `cfg_pc_bytes`: 2'd3 gives 3 bytes, 2'd2 gives 2 bytes, and 2'd1 or 2'd0 gives 1 byte. The bytes are written in the order PC bits 7:0, then 15:8, then 23:16, with the PC zero-extended above `PC_BITS`.
- R7: The first byte is written in the cycle after the accepting edge, with one write per cycle after that. Each write goes to the current stack pointer, which then decrements. In the load cycle, `sp_out` equals the captured stack pointer minus the byte count.
- R8: `pc_load` and `gie_clr` are high together for one cycle, which is the cycle right after the last write.
- R9: `busy` is high from the cycle after acceptance through the load cycle. Changes on `irq_pend`, `rst_req`, `gie`, `pc_in`, `sp_in` or the straps during that time have no effect on the sequence.
- R10: Stack pointer decrements wrap modulo 2^16, so address 16'h0000 is followed by 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req | input | 1 | Request to enter the reset vector |
| irq_pend | input | NSRC | Pending hardware interrupt sources, bit 0 highest priority |
| gie | input | 1 | Global interrupt enable |
| pc_in | input | PC_BITS | Return program counter |
| sp_in | input | SP_BITS | Current stack pointer |
| cfg_pc_bytes | input | 2 | Number of return-address bytes to stack |
| cfg_long_vec | input | 1 | 1: vector slots are two words apart |
| busy | output | 1 | Entry sequence in progress |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | SP_BITS | Data memory write address |
| mem_wdata | output | 8 | Data memory write byte |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | PC_BITS | Handler address |
| sp_out | output | SP_BITS | Updated stack pointer, valid with `pc_load` |
| gie_clr | output | 1 | Clear global interrupt enable |
| src_clr | output | NSRC | One-hot clear of the serviced source |

## Verification
The bench builds the block with NSRC = 12 and PC_BITS = 22. With 12 sources, the highest source (bit 11) maps to vector 12 and handler address 24, so the top end of the vector range is reachable. With a 22-bit PC, the third stacked byte carries only six live bits, so the zero-extension of the high byte is checked. The default 16-bit stack pointer is kept so that the wrap from 16'h0000 to 16'hFFFF can be driven directly.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NSRC    = 16,
  parameter int PC_BITS = 22,
  parameter int SP_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req,
  input  logic [NSRC-1:0]    irq_pend,
  input  logic               gie,
  input  logic [PC_BITS-1:0] pc_in,
  input  logic [SP_BITS-1:0] sp_in,
  input  logic [1:0]         cfg_pc_bytes,
  input  logic               cfg_long_vec,
  output logic               busy,
  output logic               mem_we,
  output logic [SP_BITS-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  output logic               pc_load,
  output logic [PC_BITS-1:0] pc_out,
  output logic [SP_BITS-1:0] sp_out,
  output logic               gie_clr,
  output logic [NSRC-1:0]    src_clr
);

  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int VW = $clog2(NSRC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_LOAD} st_t;

  st_t               st;
  logic [23:0]       pc_q;
  logic [SP_BITS-1:0] sp_q;
  logic [1:0]        cnt, last;
  logic [VW-1:0]     vec_q;
  logic [NSRC-1:0]   clr_q;
  logic              long_q;
  logic [SW-1:0]     sel;
  logic [1:0]        last_d;
  logic              take;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (irq_pend[i]) sel = SW'(i);
  end

  always_comb begin
    case (cfg_pc_bytes)
      2'd3:    last_d = 2'd2;
      2'd2:    last_d = 2'd1;
      default: last_d = 2'd0;
    endcase
  end

  assign take = (st == ST_IDLE) && gie && (rst_req || (|irq_pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pc_q   <= '0;
      sp_q   <= '0;
      cnt    <= '0;
      last   <= '0;
      vec_q  <= '0;
      clr_q  <= '0;
      long_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          st     <= ST_PUSH;
          pc_q   <= 24'(pc_in);
          sp_q   <= sp_in;
          cnt    <= '0;
          last   <= last_d;
          long_q <= cfg_long_vec;
          if (rst_req) begin
            vec_q <= '0;
            clr_q <= '0;
          end else begin
            vec_q <= VW'(sel) + VW'(1);
            clr_q <= NSRC'(1) << sel;
          end
        end
        ST_PUSH: begin
          sp_q <= sp_q - SP_BITS'(1);
          cnt  <= cnt + 2'd1;
          if (cnt == last) st <= ST_LOAD;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_we    = (st == ST_PUSH);
  assign mem_addr  = sp_q;
  assign mem_wdata = (cnt == 2'd0) ? pc_q[7:0] :
                     (cnt == 2'd1) ? pc_q[15:8] : pc_q[23:16];
  assign pc_load   = (st == ST_LOAD);
  assign pc_out    = long_q ? PC_BITS'({vec_q, 1'b0}) : PC_BITS'(vec_q);
  assign sp_out    = sp_q;
  assign gie_clr   = pc_load;
  assign src_clr   = pc_load ? clr_q : '0;

  p_accept_needs_gie_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(gie));

  p_single_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_clr));

  p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SP_BITS'(1)));

  p_load_after_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(mem_we));

  p_idle_after_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  localparam int NSRC = 12;
  localparam int PCB  = 22;
  localparam int SPB  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic [NSRC-1:0] irq_pend = '0;
  logic gie = 1'b0;
  logic [PCB-1:0] pc_in = '0;
  logic [SPB-1:0] sp_in = '0;
  logic [1:0] cfg_pc_bytes = 2'd1;
  logic cfg_long_vec = 1'b0;
  logic busy, mem_we, pc_load, gie_clr;
  logic [SPB-1:0] mem_addr, sp_out;
  logic [7:0] mem_wdata;
  logic [PCB-1:0] pc_out;
  logic [NSRC-1:0] src_clr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_entry_seq #(.NSRC(NSRC), .PC_BITS(PCB), .SP_BITS(SPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_pend(irq_pend), .gie(gie),
    .pc_in(pc_in), .sp_in(sp_in), .cfg_pc_bytes(cfg_pc_bytes),
    .cfg_long_vec(cfg_long_vec), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
    .pc_out(pc_out), .sp_out(sp_out), .gie_clr(gie_clr), .src_clr(src_clr));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  task automatic entry(input string req, input logic rq, input logic [NSRC-1:0] pend,
                       input logic [PCB-1:0] pcv, input logic [SPB-1:0] spv,
                       input logic [1:0] nb_cfg, input logic lng,
                       input int exp_vec, input logic [NSRC-1:0] exp_clr);
    int n;
    logic [23:0] pcx;
    n = (nb_cfg == 2'd3) ? 3 : (nb_cfg == 2'd2) ? 2 : 1;
    pcx = 24'(pcv);
    @(negedge clk);
    rst_req = rq; irq_pend = pend; pc_in = pcv; sp_in = spv;
    cfg_pc_bytes = nb_cfg; cfg_long_vec = lng; gie = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) begin
        gie = 1'b0; rst_req = ~rq; irq_pend = ~pend; pc_in = ~pcv;
        sp_in = ~spv; cfg_pc_bytes = ~nb_cfg; cfg_long_vec = ~lng;
      end
      chk("R9", "busy", 32'(busy), 32'd1);
      chk("R7", "mem_we", 32'(mem_we), 32'd1);
      chk("R10 R7", "mem_addr", 32'(mem_addr), 32'(SPB'(spv - SPB'(k))));
      chk("R6", "mem_wdata", 32'(mem_wdata), 32'(pcx[8*k +: 8]));
      chk("R8", "early pc_load", 32'(pc_load), 32'd0);
    end
    @(negedge clk);
    chk("R8", "pc_load", 32'(pc_load), 32'd1);
    chk("R8", "gie_clr", 32'(gie_clr), 32'd1);
    chk("R7", "mem_we in load", 32'(mem_we), 32'd0);
    chk("R5", "pc_out", 32'(pc_out), 32'(exp_vec * (lng ? 2 : 1)));
    chk("R10 R7", "sp_out", 32'(sp_out), 32'(SPB'(spv - SPB'(n))));
    chk("R4", "src_clr", 32'(src_clr), 32'(exp_clr));
    @(negedge clk);
    chk("R9", "busy after", 32'(busy), 32'd0);
    chk("R4", "src_clr after", 32'(src_clr), 32'd0);
    rst_req = 1'b0; irq_pend = '0;
  endtask

  task automatic t_reset_state();
    chk("R1", "reset busy", 32'(busy), 32'd0);
    chk("R1", "reset mem_we", 32'(mem_we), 32'd0);
    chk("R8", "reset pc_load", 32'(pc_load), 32'd0);
    chk("R4", "reset src_clr", 32'(src_clr), 32'd0);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    gie = 1'b0; rst_req = 1'b1; irq_pend = 12'hFFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1", "gie=0 busy", 32'(busy), 32'd0);
      chk("R1", "gie=0 mem_we", 32'(mem_we), 32'd0);
    end
    rst_req = 1'b0; irq_pend = '0; gie = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "no request busy", 32'(busy), 32'd0);
      chk("R1", "no request pc_load", 32'(pc_load), 32'd0);
    end
    gie = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_disabled();
    entry("R3", 1'b0, 12'h008, 22'h12345, 16'h0400, 2'd2, 1'b1, 4, 12'h008);
    entry("R3", 1'b0, 12'hA40, 22'h3ABCDE, 16'h8000, 2'd3, 1'b0, 7, 12'h040);
    entry("R3", 1'b0, 12'hFFF, 22'h000077, 16'h1234, 2'd1, 1'b1, 1, 12'h001);
    entry("R2", 1'b1, 12'h005, 22'h2A5A5, 16'h0100, 2'd1, 1'b1, 0, 12'h000);
    entry("R6", 1'b0, 12'h010, 22'h1FF00, 16'h0050, 2'd0, 1'b0, 5, 12'h010);
    entry("R10", 1'b0, 12'h100, 22'h3F1234, 16'h0001, 2'd3, 1'b1, 9, 12'h100);
    entry("R5", 1'b0, 12'h800, 22'h000ABC, 16'hFFFF, 2'd2, 1'b1, 12, 12'h800);
    finish_run();
  end
endmodule